// File: doc/BRIEF.md
# DMA Transfer Address Generator

This block produces the read and write address sequence for a single DMA channel. A start pulse captures a source base, a destination base, a transfer unit size code, one increment code for each side, a beat count per line held as count minus one, a line count minus one, two line strides and two mode enables. From then on the block offers one beat at a time on a valid/ready handshake. Each beat carries the read address, the write address and the unit size code.

In the default linear mode a single line of beats is issued, followed by a one-cycle done pulse. With the rectangle enable set, the block walks several lines. Each new line begins at the previous line's start address plus that side's stride, not at the last incremented address. With the repeat enable set, the block never finishes on its own. After the last beat of the last line it returns to the base addresses and runs the whole pattern again until an abort arrives. The data path, bus protocol and descriptor fetching are not part of the block.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `beat_valid` and `done` are low.
- R2: A `start` pulse while idle latches all configuration inputs. In the next cycle `beat_valid` is high, `rd_addr` equals the source base, `wr_addr` equals the destination base, and `beat_size` equals the latched size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes).
- R3: After each accepted beat (valid and ready both high) inside a line, `rd_addr` advances by the source increment code: 0 adds 1, 1 adds 2, 2 adds 4, 3 adds nothing.
- R4: `wr_addr` advances the same way under the destination increment code, independently of the source code and of the size code.
- R5: Every line holds exactly `cnt_m1`+1 beats. The largest value, 1023, gives 1024 beats.
- R6: When repeat mode is off, `done` is high for exactly one cycle, in the cycle after the last beat of the last line is accepted. In that cycle `busy` and `beat_valid` are low.
- R7: With rectangle mode on, `lines_m1`+1 lines are issued. Line k starts at base + k×stride on each side, with the stride counted in bytes.
- R8: With rectangle mode off, `lines_m1` and both strides have no effect: exactly one line is issued.
- R9: With repeat mode on, after the last beat of the last line the next beat starts again at both base addresses, and `done` stays low.
- R10: A `start` while busy is ignored. The running sequence and its latched configuration continue unchanged.
- R11: `abort` returns the block to idle in the next cycle without a `done` pulse. Abort takes precedence over `start` and over a beat accepted in the same cycle.
- R12: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `rd_addr` and `wr_addr` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer with the configuration inputs (honoured only when idle) |
| abort | input | 1 | Return to idle without completion |
| cfg_src_base | input | ADDR_W | First read address |
| cfg_dst_base | input | ADDR_W | First write address |
| cfg_size | input | 2 | Unit size code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| cfg_src_inc | input | 2 | Source increment code: 0 = +1, 1 = +2, 2 = +4, 3 = hold |
| cfg_dst_inc | input | 2 | Destination increment code, same encoding |
| cfg_cnt_m1 | input | CNT_W | Beats per line minus one |
| cfg_rect_en | input | 1 | Enable multi-line rectangle walk |
| cfg_lines_m1 | input | LINE_W | Lines minus one (rectangle mode only) |
| cfg_src_stride | input | STRIDE_W | Source byte distance between line starts |
| cfg_dst_stride | input | STRIDE_W | Destination byte distance between line starts |
| cfg_loop_en | input | 1 | Repeat the whole pattern instead of finishing |
| beat_valid | output | 1 | A beat is offered |
| beat_ready | input | 1 | Consumer accepts the offered beat |
| rd_addr | output | ADDR_W | Read address of the offered beat |
| wr_addr | output | ADDR_W | Write address of the offered beat |
| beat_size | output | 2 | Unit size code of the offered beat |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong beat or line counter appears at the ports as a line that is too short or too long. The bench sees this at the first beat where the expected address differs, or as a done pulse that comes early, comes late, or never comes. A corrupted line-start register appears at the first address of the next line. A wrong increment appears one accepted beat after the fault. Any state that survives a stall, an ignored start or an abort when it should not shows up in the next offered address or in a stray done.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [1:0] {
        STEP_1    = 2'd0,
        STEP_2    = 2'd1,
        STEP_4    = 2'd2,
        STEP_HOLD = 2'd3
    } step_code_e;

    typedef enum logic [1:0] {
        UNIT_1B = 2'd0,
        UNIT_2B = 2'd1,
        UNIT_4B = 2'd2
    } unit_code_e;

    localparam int NUM_LANES = 2;
    localparam int LANE_SRC  = 0;
    localparam int LANE_DST  = 1;

    function automatic logic [2:0] step_bytes(step_code_e code);
        case (code)
            STEP_1:  return 3'd1;
            STEP_2:  return 3'd2;
            STEP_4:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dag_lane.sv
module dag_lane
    import dag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    input  logic                next_line,
    input  logic                restart,
    input  logic [ADDR_W-1:0]   base_in,
    input  logic [1:0]          inc_in,
    input  logic [STRIDE_W-1:0] stride_in,
    output logic [ADDR_W-1:0]   addr
);
    localparam int PAD_INC    = ADDR_W - 3;
    localparam int PAD_STRIDE = ADDR_W - STRIDE_W;

    logic [ADDR_W-1:0]   base_q;
    logic [ADDR_W-1:0]   line_q;
    logic [ADDR_W-1:0]   cur_q;
    step_code_e          inc_q;
    logic [STRIDE_W-1:0] stride_q;

    logic [ADDR_W-1:0] inc_ext;
    logic [ADDR_W-1:0] next_line_addr;

    always_comb begin
        inc_ext        = {{PAD_INC{1'b0}}, step_bytes(inc_q)};
        next_line_addr = line_q + {{PAD_STRIDE{1'b0}}, stride_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            line_q   <= '0;
            cur_q    <= '0;
            inc_q    <= STEP_1;
            stride_q <= '0;
        end else if (load) begin
            base_q   <= base_in;
            line_q   <= base_in;
            cur_q    <= base_in;
            inc_q    <= step_code_e'(inc_in);
            stride_q <= stride_in;
        end else if (restart) begin
            line_q <= base_q;
            cur_q  <= base_q;
        end else if (next_line) begin
            line_q <= next_line_addr;
            cur_q  <= next_line_addr;
        end else if (step) begin
            cur_q <= cur_q + inc_ext;
        end
    end

    assign addr = cur_q;

    // R12: with no advance request of any kind the address is held
    a_r12_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !step && !next_line && !restart) |=> $stable(addr));

    // R9: a restart lands on the base address captured at load
    a_r9_restart_base: assert property (@(posedge clk) disable iff (rst)
        (restart && !load) |=> (addr == base_q));

endmodule

// File: rtl/dag_count.sv
module dag_count #(
    parameter int CNT_W  = 10,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [CNT_W-1:0]  cnt_m1_in,
    input  logic [LINE_W-1:0] lines_m1_in,
    output logic              last_beat,
    output logic              last_line
);
    logic [CNT_W-1:0]  cnt_lim_q;
    logic [LINE_W-1:0] line_lim_q;
    logic [CNT_W-1:0]  beat_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lim_q  <= '0;
            line_lim_q <= '0;
            beat_q     <= '0;
            line_q     <= '0;
        end else if (load) begin
            cnt_lim_q  <= cnt_m1_in;
            line_lim_q <= lines_m1_in;
            beat_q     <= '0;
            line_q     <= '0;
        end else if (adv) begin
            if (last_beat) begin
                beat_q <= '0;
                line_q <= last_line ? '0 : line_q + 1'b1;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign last_beat = (beat_q == cnt_lim_q);
    assign last_line = (line_q == line_lim_q);

    // R5: the beat index never passes the programmed limit
    a_r5_beat_bound: assert property (@(posedge clk) disable iff (rst)
        beat_q <= cnt_lim_q);

    // R7: the line index never passes the programmed line limit
    a_r7_line_bound: assert property (@(posedge clk) disable iff (rst)
        line_q <= line_lim_q);

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 10,
    parameter int LINE_W   = 10,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  logic [ADDR_W-1:0]   cfg_src_base,
    input  logic [ADDR_W-1:0]   cfg_dst_base,
    input  logic [1:0]          cfg_size,
    input  logic [1:0]          cfg_src_inc,
    input  logic [1:0]          cfg_dst_inc,
    input  logic [CNT_W-1:0]    cfg_cnt_m1,
    input  logic                cfg_rect_en,
    input  logic [LINE_W-1:0]   cfg_lines_m1,
    input  logic [STRIDE_W-1:0] cfg_src_stride,
    input  logic [STRIDE_W-1:0] cfg_dst_stride,
    input  logic                cfg_loop_en,
    output logic                beat_valid,
    input  logic                beat_ready,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [1:0]          beat_size,
    output logic                busy,
    output logic                done
);
    logic       busy_q;
    logic       done_q;
    logic       loop_q;
    unit_code_e size_q;

    logic load;
    logic fire;
    logic last_beat;
    logic last_line;
    logic end_pass;
    logic lane_step;
    logic lane_next_line;
    logic lane_restart;

    logic [LINE_W-1:0] lines_eff;

    always_comb begin
        load           = start && !busy_q && !abort;
        fire           = busy_q && beat_ready && !abort;
        end_pass       = fire && last_beat && last_line;
        lane_step      = fire && !last_beat;
        lane_next_line = fire && last_beat && !last_line;
        lane_restart   = end_pass;
        lines_eff      = cfg_rect_en ? cfg_lines_m1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            loop_q <= 1'b0;
            size_q <= UNIT_1B;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
            end else if (load) begin
                busy_q <= 1'b1;
                loop_q <= cfg_loop_en;
                size_q <= unit_code_e'(cfg_size);
            end else if (end_pass && !loop_q) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    dag_count #(
        .CNT_W  (CNT_W),
        .LINE_W (LINE_W)
    ) u_count (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .adv         (fire),
        .cnt_m1_in   (cfg_cnt_m1),
        .lines_m1_in (lines_eff),
        .last_beat   (last_beat),
        .last_line   (last_line)
    );

    logic [ADDR_W-1:0]   lane_base   [NUM_LANES];
    logic [1:0]          lane_inc    [NUM_LANES];
    logic [STRIDE_W-1:0] lane_stride [NUM_LANES];
    logic [ADDR_W-1:0]   lane_addr   [NUM_LANES];

    always_comb begin
        lane_base[LANE_SRC]   = cfg_src_base;
        lane_base[LANE_DST]   = cfg_dst_base;
        lane_inc[LANE_SRC]    = cfg_src_inc;
        lane_inc[LANE_DST]    = cfg_dst_inc;
        lane_stride[LANE_SRC] = cfg_src_stride;
        lane_stride[LANE_DST] = cfg_dst_stride;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dag_lane #(
            .ADDR_W   (ADDR_W),
            .STRIDE_W (STRIDE_W)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .step      (lane_step),
            .next_line (lane_next_line),
            .restart   (lane_restart),
            .base_in   (lane_base[g]),
            .inc_in    (lane_inc[g]),
            .stride_in (lane_stride[g]),
            .addr      (lane_addr[g])
        );
    end

    assign beat_valid = busy_q;
    assign busy       = busy_q;
    assign done       = done_q;
    assign beat_size  = size_q;
    assign rd_addr    = lane_addr[LANE_SRC];
    assign wr_addr    = lane_addr[LANE_DST];

    // R1: reset leaves the block idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !beat_valid && !done));

    // R6: done lasts one cycle and coincides with idle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !beat_valid));

    // R11: abort reaches idle with no completion
    a_r11_abort_idle: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !done));

    // R10: a start while busy leaves the latched size untouched
    a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !abort) |=> (busy || done) && $stable(beat_size));

    // R12: an offered beat is held until taken
    a_r12_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready && !abort) |=>
            (beat_valid && $stable(rd_addr) && $stable(wr_addr)));

endmodule

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [31:0] cfg_src_base = '0;
    logic [31:0] cfg_dst_base = '0;
    logic [1:0]  cfg_size = '0;
    logic [1:0]  cfg_src_inc = '0;
    logic [1:0]  cfg_dst_inc = '0;
    logic [9:0]  cfg_cnt_m1 = '0;
    logic        cfg_rect_en = 1'b0;
    logic [9:0]  cfg_lines_m1 = '0;
    logic [15:0] cfg_src_stride = '0;
    logic [15:0] cfg_dst_stride = '0;
    logic        cfg_loop_en = 1'b0;
    logic        beat_ready = 1'b1;
    logic        beat_valid;
    logic [31:0] rd_addr;
    logic [31:0] wr_addr;
    logic [1:0]  beat_size;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    // expected configuration, kept by the bench
    logic [31:0] e_sb, e_db;
    logic [1:0]  e_sz, e_si, e_di;
    int          e_cnt, e_lines, e_ss, e_ds;

    always #10 clk = ~clk;

    dma_addr_gen i_dma_addr_gen (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
        .cfg_size(cfg_size), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .cfg_cnt_m1(cfg_cnt_m1), .cfg_rect_en(cfg_rect_en), .cfg_lines_m1(cfg_lines_m1),
        .cfg_src_stride(cfg_src_stride), .cfg_dst_stride(cfg_dst_stride),
        .cfg_loop_en(cfg_loop_en), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .beat_size(beat_size),
        .busy(busy), .done(done)
    );

    function automatic int step_of(logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic launch(logic [31:0] sb, logic [31:0] db, logic [1:0] sz,
                          logic [1:0] si, logic [1:0] di, int cnt,
                          logic rect, int lines, int ss, int ds, logic lp);
        cfg_src_base = sb; cfg_dst_base = db; cfg_size = sz;
        cfg_src_inc = si; cfg_dst_inc = di; cfg_cnt_m1 = 10'(cnt);
        cfg_rect_en = rect; cfg_lines_m1 = 10'(lines);
        cfg_src_stride = 16'(ss); cfg_dst_stride = 16'(ds); cfg_loop_en = lp;
        e_sb = sb; e_db = db; e_sz = sz; e_si = si; e_di = di; e_cnt = cnt;
        e_lines = rect ? lines : 0; e_ss = ss; e_ds = ds;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // check one offered beat at this negedge, then let it be taken
    task automatic expect_beat(string req, int line, int beat);
        chk(req, {31'd0, beat_valid}, 32'd1);
        chk(req, rd_addr, e_sb + 32'(line * e_ss) + 32'(beat * step_of(e_si)));
        chk(req, wr_addr, e_db + 32'(line * e_ds) + 32'(beat * step_of(e_di)));
        chk(req, {30'd0, beat_size}, {30'd0, e_sz});
        @(negedge clk);
    endtask

    task automatic walk(string req);
        for (int l = 0; l <= e_lines; l++)
            for (int b = 0; b <= e_cnt; b++)
                expect_beat(req, l, b);
    endtask

    task automatic expect_done(string req);
        chk(req, {29'd0, done, busy, beat_valid}, 32'b100);
        @(negedge clk);
        chk(req, {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1", {29'd0, busy, beat_valid, done}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", {29'd0, busy, beat_valid, done}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_linear;
        // R2 R3 R4 R5 R6: distinct codes on each side
        launch(32'h1000, 32'h8000, 2'd2, 2'd2, 2'd0, 4, 1'b0, 0, 0, 0, 1'b0);
        walk("R3 R4 R5");
        expect_done("R6");
        launch(32'h2001, 32'h4000, 2'd1, 2'd3, 2'd1, 3, 1'b0, 0, 0, 0, 1'b0);
        walk("R2 R3 R4");
        expect_done("R6");
        launch(32'h30, 32'h50, 2'd0, 2'd1, 2'd3, 0, 1'b0, 0, 0, 0, 1'b0);
        walk("R5 single beat");
        expect_done("R6");
    endtask

    task automatic t_rect;
        // R7: three lines of three beats, strides in bytes
        launch(32'h100, 32'h900, 2'd2, 2'd2, 2'd1, 2, 1'b1, 2, 64, 40, 1'b0);
        walk("R7");
        expect_done("R7");
        // R8: rectangle off, lines and strides ignored
        launch(32'h200, 32'hA00, 2'd0, 2'd0, 2'd0, 1, 1'b0, 5, 128, 128, 1'b0);
        walk("R8");
        expect_done("R8");
    endtask

    task automatic t_stall;
        launch(32'h500, 32'h600, 2'd1, 2'd1, 2'd1, 3, 1'b0, 0, 0, 0, 1'b0);
        expect_beat("R12", 0, 0);
        beat_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R12 held", rd_addr, e_sb + 32'd2);
            chk("R12 held", wr_addr, e_db + 32'd2);
            chk("R12 valid", {31'd0, beat_valid}, 32'd1);
        end
        beat_ready = 1'b1;
        for (int b = 1; b <= 3; b++) expect_beat("R12 resume", 0, b);
        expect_done("R6");
    endtask

    task automatic t_busy_start;
        launch(32'h700, 32'h7100, 2'd2, 2'd2, 2'd2, 3, 1'b0, 0, 0, 0, 1'b0);
        expect_beat("R10", 0, 0);
        beat_ready = 1'b0;
        cfg_src_base = 32'hDEAD0; cfg_dst_base = 32'hBEEF0; cfg_size = 2'd0;
        cfg_src_inc = 2'd3; cfg_cnt_m1 = 10'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 addr kept", rd_addr, e_sb + 32'd4);
        beat_ready = 1'b1;
        for (int b = 1; b <= 3; b++) expect_beat("R10", 0, b);
        expect_done("R10");
    endtask

    task automatic t_loop;
        launch(32'h40, 32'hC0, 2'd0, 2'd0, 2'd2, 2, 1'b1, 1, 16, 32, 1'b1);
        for (int p = 0; p < 3; p++)
            for (int l = 0; l <= 1; l++)
                for (int b = 0; b <= 2; b++) begin
                    chk("R9 no done", {31'd0, done}, 32'd0);
                    expect_beat("R9", l, b);
                end
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R11", {30'd0, busy, done}, 32'd0);
        @(negedge clk);
        chk("R11 no done", {30'd0, busy, done}, 32'd0);
    endtask

    task automatic t_abort;
        launch(32'h900, 32'h990, 2'd1, 2'd1, 2'd1, 5, 1'b0, 0, 0, 0, 1'b0);
        expect_beat("R11", 0, 0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R11", {29'd0, busy, beat_valid, done}, 32'd0);
        @(negedge clk);
        chk("R11", {29'd0, busy, beat_valid, done}, 32'd0);
        // abort beats start in the same cycle
        cfg_cnt_m1 = 10'd0;
        start = 1'b1; abort = 1'b1;
        @(negedge clk);
        start = 1'b0; abort = 1'b0;
        chk("R11 over start", {31'd0, busy}, 32'd0);
        // abort on the final beat: no done
        launch(32'h10, 32'h20, 2'd0, 2'd0, 2'd0, 0, 1'b0, 0, 0, 0, 1'b0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R11 last beat", {30'd0, busy, done}, 32'd0);
    endtask

    task automatic t_max;
        launch(32'h0, 32'h10000, 2'd2, 2'd2, 2'd2, 1023, 1'b0, 0, 0, 0, 1'b0);
        walk("R5 max");
        expect_done("R5 max");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_linear();
        t_rect();
        t_stall();
        t_busy_start();
        t_loop();
        t_abort();
        t_max();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule